// File: doc/BRIEF.md
# Beam-Synchronized Display-List Coprocessor

This block is a small instruction sequencer that walks a list of 16-bit instruction word pairs held in memory and acts on them in step with the video beam. It fetches words through a request/grant memory port. It places register writes on a narrow write bus that carries a 9-bit destination address and 16-bit data. Three kinds of instruction exist. A register-write instruction places an immediate value on the write bus. A hold instruction parks the sequencer until the beam has reached a target position. A conditional-bypass instruction jumps over the next instruction pair when the beam has already reached its target.

The beam position is compared by magnitude against a target, and the comparison covers only the bits that the instruction enables. The top vertical bit is always compared. An optional gate also waits for a blitter-finished flag. Requests go out only during odd memory slots, so a two-word instruction occupies four memory slots. Two 18-bit jump-location registers define where the list starts. A jump strobe loads the matching register into the program counter. The vertical-blank pulse reloads location 0.

Top module: `beam_copro`

## Requirements
- R1: After reset, `mem_req` and `reg_wr` stay low until a jump strobe or `vblank` has loaded the program counter. While `dma_en` is low, `mem_req` stays low.
- R2: `mem_req` is high only in cycles where `slot_odd` is high. When every request is granted, the first words of two consecutive instructions are granted exactly 4 cycles apart.
- R3: A pulse on `jump_stb[i]` loads location register i into the program counter. `mem_addr` is the stored byte address with bit 0 cleared. When strobes coincide, the lowest index wins. Any strobe wins over `vblank`.
- R4: A `vblank` pulse with no strobe in the same cycle loads location register 0 and restarts fetching from that address.
- R5: An instruction whose first word has bit 0 = 0 writes to the register bus. In the cycle after its second word is granted, `reg_wr`=1, `reg_addr`={word1[8:1],0} and `reg_data`=word2.
- R6: Every granted fetch except the second word of a register-write instruction produces, one cycle after the grant, `reg_wr`=1 with `reg_addr`=FETCH_ID (default 9'h0FE) and `reg_data` equal to the fetched word.
- R7: First word bit 0 = 1 with second word bit 0 = 0 is a hold. The target is word1[15:8] for vertical and word1[7:1] for horizontal bits 8..2. The hold ends when the enabled beam bits are greater than or equal to the enabled target bits, compared as one number with vertical above horizontal. Until then, no request is issued.
- R8: The mask bits are word2[14:8], which enable vertical bits 6..0, and word2[7:1], which enable horizontal bits 8..2. A bit whose mask is 0 does not take part in the comparison. Vertical bit 7 always takes part.
- R9: When word2[15] = 0, the condition also requires `blit_done`=1. When word2[15] = 1, `blit_done` is ignored.
- R10: First word bit 0 = 1 with second word bit 0 = 1 is a conditional bypass. If the condition holds, the next two words are not fetched and fetching resumes 6 bytes after the second word. Otherwise, the next instruction runs normally.
- R11: Each granted fetch advances `mem_addr` by 2. A request that is not granted is repeated at the same address in a later odd slot, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Permits memory requests |
| slot_odd | input | 1 | High during odd memory slots |
| beam_v | input | 8 | Current vertical beam position |
| beam_h | input | 9 | Current horizontal beam position |
| blit_done | input | 1 | Blitter-finished flag |
| vblank | input | 1 | Vertical-blank start pulse |
| loc_wr | input | 2 | Per-register write enable for the jump locations |
| loc_wdata | input | 18 | Jump location write data (byte address) |
| jump_stb | input | 2 | Jump strobes, one per location register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 18 | Memory byte address of the requested word |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| reg_wr | output | 1 | Register bus write strobe |
| reg_addr | output | 9 | Register bus destination byte address |
| reg_data | output | 16 | Register bus data |

## Verification
The bench runs holds whose beam input sits one step below the target, then exactly at it, then above it. A design that compares for equality, or that compares the wrong way, either hangs or releases early. Holds with every mask bit cleared check two things: the top vertical bit must still block, and a fully masked target must pass at once. A design that masks vertical bit 7 releases too early, and one that ignores the mask stalls. The bench also checks the bypass jump distance against the granted addresses, withheld grants, and coinciding strobes and blanking. A wrong skip length or a dropped retry shows up as a misplaced register write, and a wrong load priority starts the wrong list.

// File: rtl/beam_copro_pkg.sv
`timescale 1ns/1ps
package beam_copro_pkg;
  localparam int WORD_W = 16;
  localparam int REG_AW = 9;
  localparam int WORD_BYTES = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_W1   = 2'd1,
    ST_W2   = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_t;

  // Masked beam comparison: vertical above horizontal, v7 never masked.
  function automatic logic beam_reached(
    input logic [7:0]        v,
    input logic [8:0]        h,
    input logic [WORD_W-1:0] tgt_w,
    input logic [WORD_W-1:0] msk_w,
    input logic              blit_done
  );
    logic [14:0] en;
    logic [14:0] cur;
    logic [14:0] tgt;
    en  = {1'b1, msk_w[14:8], msk_w[7:1]};
    cur = {v, h[8:2]} & en;
    tgt = tgt_w[15:1] & en;
    return (cur >= tgt) && (msk_w[15] || blit_done);
  endfunction
endpackage

// File: rtl/beam_copro_locs.sv
`timescale 1ns/1ps
module beam_copro_locs #(
  parameter int ADDR_W  = 18,
  parameter int NUM_LOC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LOC-1:0] loc_wr,
  input  logic [ADDR_W-1:0] loc_wdata,
  input  logic [NUM_LOC-1:0] jump_stb,
  input  logic              vblank,
  output logic              load_vld,
  output logic [ADDR_W-1:0] load_pc
);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~(ADDR_W'(1));

  logic [ADDR_W-1:0] loc_q [NUM_LOC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOC; i++) loc_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_LOC; i++)
        if (loc_wr[i]) loc_q[i] <= loc_wdata;
    end
  end

  // Lowest strobe index wins; blanking falls back to location 0.
  always_comb begin
    load_vld = (|jump_stb) || vblank;
    load_pc  = loc_q[0] & EVEN_MASK;
    for (int i = NUM_LOC - 1; i >= 0; i--)
      if (jump_stb[i]) load_pc = loc_q[i] & EVEN_MASK;
  end

  p_even_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |-> (load_pc[0] == 1'b0));
endmodule

// File: rtl/beam_copro_cmp.sv
`timescale 1ns/1ps
module beam_copro_cmp
  import beam_copro_pkg::*;
(
  input  logic [7:0]        beam_v,
  input  logic [8:0]        beam_h,
  input  logic              blit_done,
  input  logic [WORD_W-1:0] tgt_word,
  input  logic [WORD_W-1:0] msk_word,
  output logic              reached
);
  always_comb reached = beam_reached(beam_v, beam_h, tgt_word, msk_word, blit_done);

  // R8: the top vertical bit blocks whatever the mask says
  always_comb begin
    if (tgt_word[15] && !beam_v[7])
      p_v7_unmasked_r8: assert (!reached);
    if (!msk_word[15] && !blit_done)
      p_blit_gate_r9: assert (!reached);
  end
endmodule

// File: rtl/beam_copro_seq.sv
`timescale 1ns/1ps
module beam_copro_seq
  import beam_copro_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter logic [REG_AW-1:0] FETCH_ID = 9'h0FE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              slot_odd,
  input  logic              load_vld,
  input  logic [ADDR_W-1:0] load_pc,
  input  logic              cond_met,
  output logic [WORD_W-1:0] tgt_word,
  output logic [WORD_W-1:0] msk_word,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              reg_wr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_data
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * WORD_BYTES);

  seq_state_t        state;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] ir1;
  logic [WORD_W-1:0] hold_q;
  logic              take;
  logic              is_move;
  logic              is_skip;

  always_comb begin
    mem_req  = dma_en && slot_odd && (state == ST_W1 || state == ST_W2);
    mem_addr = pc;
    take     = mem_req && mem_gnt;
    is_move  = !ir1[0];
    is_skip  = mem_rdata[0];
    tgt_word = ir1;
    msk_word = (state == ST_HOLD) ? hold_q : mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pc       <= '0;
      ir1      <= '0;
      hold_q   <= '0;
      reg_wr   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (load_vld) begin
        pc    <= load_pc;
        state <= ST_W1;
      end else begin
        unique case (state)
          ST_W1: if (take) begin
            ir1      <= mem_rdata;
            pc       <= pc + STEP1;
            state    <= ST_W2;
            reg_wr   <= 1'b1;
            reg_addr <= FETCH_ID;
            reg_data <= mem_rdata;
          end
          ST_W2: if (take) begin
            reg_wr   <= 1'b1;
            reg_data <= mem_rdata;
            if (is_move) begin
              reg_addr <= {ir1[8:1], 1'b0};
              pc       <= pc + STEP1;
              state    <= ST_W1;
            end else begin
              reg_addr <= FETCH_ID;
              hold_q   <= mem_rdata;
              if (is_skip) begin
                pc    <= cond_met ? pc + STEP3 : pc + STEP1;
                state <= ST_W1;
              end else begin
                pc    <= pc + STEP1;
                state <= cond_met ? ST_W1 : ST_HOLD;
              end
            end
          end
          ST_HOLD: if (cond_met) state <= ST_W1;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |=> (state == ST_W1 && mem_addr == $past(load_pc)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !load_vld) |=> !mem_req);
  p_wr_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(take));
  p_fetch_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state == ST_W1 && !load_vld) |=>
      (reg_wr && reg_addr == FETCH_ID && reg_data == $past(mem_rdata)));
  p_move_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state == ST_W2 && is_move && !load_vld) |=>
      (reg_wr && reg_addr == {$past(ir1[8:1]), 1'b0} && reg_data == $past(mem_rdata)));
  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state == ST_W1 && !load_vld) |=> (mem_addr == $past(mem_addr) + STEP1));
  p_retry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !load_vld) |=> $stable(mem_addr));
  p_hold_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !cond_met && !load_vld) |=> (state == ST_HOLD && !mem_req));
endmodule

// File: rtl/beam_copro.sv
`timescale 1ns/1ps
module beam_copro
  import beam_copro_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter int                NUM_LOC  = 2,
  parameter logic [REG_AW-1:0] FETCH_ID = 9'h0FE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               slot_odd,
  input  logic [7:0]         beam_v,
  input  logic [8:0]         beam_h,
  input  logic               blit_done,
  input  logic               vblank,
  input  logic [NUM_LOC-1:0] loc_wr,
  input  logic [ADDR_W-1:0]  loc_wdata,
  input  logic [NUM_LOC-1:0] jump_stb,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_gnt,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               reg_wr,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [WORD_W-1:0]  reg_data
);
  logic              load_vld;
  logic [ADDR_W-1:0] load_pc;
  logic              cond_met;
  logic [WORD_W-1:0] tgt_word;
  logic [WORD_W-1:0] msk_word;

  beam_copro_locs #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC)) u_locs (
    .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
    .jump_stb(jump_stb), .vblank(vblank), .load_vld(load_vld), .load_pc(load_pc)
  );

  beam_copro_cmp u_cmp (
    .beam_v(beam_v), .beam_h(beam_h), .blit_done(blit_done),
    .tgt_word(tgt_word), .msk_word(msk_word), .reached(cond_met)
  );

  beam_copro_seq #(.ADDR_W(ADDR_W), .FETCH_ID(FETCH_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .slot_odd(slot_odd),
    .load_vld(load_vld), .load_pc(load_pc), .cond_met(cond_met),
    .tgt_word(tgt_word), .msk_word(msk_word),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data)
  );
endmodule

// File: tb/beam_copro_tb.sv
`timescale 1ns/1ps
module beam_copro_tb;
  localparam logic [8:0] FID = 9'h0FE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic        slot_odd = 1'b0;
  logic [7:0]  beam_v = '0;
  logic [8:0]  beam_h = '0;
  logic        blit_done = 1'b0;
  logic        vblank = 1'b0;
  logic [1:0]  loc_wr = '0;
  logic [17:0] loc_wdata = '0;
  logic [1:0]  jump_stb = '0;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_gnt;
  logic [15:0] mem_rdata;
  logic        reg_wr;
  logic [8:0]  reg_addr;
  logic [15:0] reg_data;
  logic        gnt_en = 1'b1;

  logic [15:0] mem [128];
  logic [24:0] expq [$];
  logic [17:0] glog_a [$];
  int          glog_t [$];
  int n_chk = 0, n_fail = 0, cyc = 0, req_cnt = 0;

  always #2 clk = ~clk;

  beam_copro u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .slot_odd(slot_odd),
    .beam_v(beam_v), .beam_h(beam_h), .blit_done(blit_done), .vblank(vblank),
    .loc_wr(loc_wr), .loc_wdata(loc_wdata), .jump_stb(jump_stb),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data)
  );

  assign mem_gnt   = mem_req && gnt_en;
  assign mem_rdata = mem[mem_addr[7:1]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    slot_odd <= rst_n ? ~slot_odd : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard for the register bus plus grant logging
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        req_cnt++;
        chk(slot_odd, "R2 request outside odd slot", 32'(slot_odd), 1);
      end
      if (mem_req && mem_gnt) begin
        glog_a.push_back(mem_addr);
        glog_t.push_back(cyc);
      end
      if (reg_wr) begin
        if (expq.size() == 0)
          chk(1'b0, "R6 unexpected register write", {7'd0, reg_addr, reg_data}, 0);
        else begin
          logic [24:0] e;
          e = expq.pop_front();
          chk({reg_addr, reg_data} == e, "R5/R6 register write", {7'd0, reg_addr, reg_data}, {7'd0, e});
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_loc(input int i, input logic [17:0] v);
    @(posedge clk); #1;
    loc_wr = 2'b01 << i; loc_wdata = v;
    @(posedge clk); #1;
    loc_wr = '0;
  endtask

  task automatic pulse(input logic [1:0] stb, input logic vb);
    @(posedge clk); #1;
    jump_stb = stb; vblank = vb;
    @(posedge clk); #1;
    jump_stb = '0; vblank = 1'b0;
  endtask

  function automatic logic [15:0] mv1(input logic [8:0] da);
    return {7'd0, da[8:1], 1'b0};
  endfunction
  function automatic logic [15:0] ws1(input logic [7:0] v, input logic [8:0] h);
    return {v, h[8:2], 1'b1};
  endfunction
  function automatic logic [15:0] ws2(input logic bfd, input logic [6:0] vm, input logic [6:0] hm, input logic sk);
    return {bfd, vm, hm, sk};
  endfunction

  // Driver helpers: each pushes what the register bus must show
  task automatic exp_fetch(input logic [15:0] w);
    expq.push_back({FID, w});
  endtask
  task automatic exp_move(input logic [8:0] da, input logic [15:0] d);
    exp_fetch(mv1(da));
    expq.push_back({da & 9'h1FE, d});
  endtask
  task automatic exp_stop();
    exp_fetch(16'hFFFF); exp_fetch(16'hFFFE);
  endtask
  task automatic put_move(input int idx, input logic [8:0] da, input logic [15:0] d);
    mem[idx] = mv1(da); mem[idx+1] = d;
  endtask
  task automatic put_stop(input int idx);
    mem[idx] = 16'hFFFF; mem[idx+1] = 16'hFFFE;
  endtask
  task automatic drain(input int n, input string tag);
    tick(n);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask
  task automatic clear_log();
    glog_a.delete(); glog_t.delete();
  endtask

  initial begin
    int rc;
    for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
    // A at byte 0x00
    put_move(0, 9'h040, 16'h1234); put_move(2, 9'h1FE, 16'hBEEF); put_stop(4);
    // B at byte 0x20
    put_move(16, 9'h0AA, 16'h5A5A); put_stop(18);
    // C at byte 0x40
    mem[32] = ws1(8'h30, 9'h000); mem[33] = ws2(1, 7'h7F, 7'h7F, 0);
    put_move(34, 9'h050, 16'h1111);
    mem[36] = ws1(8'h30, 9'h100); mem[37] = ws2(1, 7'h7F, 7'h7F, 0);
    put_move(38, 9'h052, 16'h1112); put_stop(40);
    // D at byte 0x60
    mem[48] = ws1(8'h7F, 9'h1FC); mem[49] = ws2(1, 7'h00, 7'h00, 0);
    put_move(50, 9'h060, 16'h2222);
    mem[52] = ws1(8'h80, 9'h000); mem[53] = ws2(1, 7'h00, 7'h00, 0);
    put_move(54, 9'h062, 16'h3333); put_stop(56);
    // E at byte 0x80
    mem[64] = ws1(8'h00, 9'h000); mem[65] = ws2(0, 7'h7F, 7'h7F, 0);
    put_move(66, 9'h070, 16'h4444); put_stop(68);
    // F at byte 0xA0
    mem[80] = ws1(8'h00, 9'h000); mem[81] = ws2(1, 7'h7F, 7'h7F, 1);
    put_move(82, 9'h080, 16'hAAAA); put_move(84, 9'h082, 16'hBBBB);
    mem[86] = ws1(8'h7E, 9'h000); mem[87] = ws2(1, 7'h7F, 7'h7F, 1);
    put_move(88, 9'h084, 16'hCCCC); put_stop(90);

    // R1: reset state
    tick(3);
    chk(mem_req == 0 && reg_wr == 0, "R1 outputs during reset", {mem_req, reg_wr}, 0);
    rst_n = 1'b1; dma_en = 1'b1;
    tick(20);
    chk(req_cnt == 0, "R1 no fetch before a program counter load", req_cnt, 0);

    // R1: DMA gate, then R5/R6/R11/R2 on list A
    dma_en = 1'b0;
    set_loc(0, 18'h00001);
    pulse(2'b01, 0);
    tick(10);
    chk(req_cnt == 0, "R1 no fetch with DMA disabled", req_cnt, 0);
    clear_log();
    exp_move(9'h040, 16'h1234); exp_move(9'h1FE, 16'hBEEF); exp_stop();
    dma_en = 1'b1;
    drain(40, "R5 list A complete");
    chk(glog_a.size() == 6, "R11 list A grant count", glog_a.size(), 6);
    if (glog_a.size() == 6) begin
      chk(glog_a[0] == 18'h0, "R3 start address has bit 0 cleared", glog_a[0], 0);
      chk(glog_a[3] == 18'h6, "R11 sequential word addresses", glog_a[3], 6);
      chk(glog_t[2] - glog_t[0] == 4, "R2 four slots per instruction", glog_t[2] - glog_t[0], 4);
    end

    // R3/R11: jump via location 1 with grants withheld first
    set_loc(1, 18'h00020);
    clear_log();
    gnt_en = 1'b0;
    exp_move(9'h0AA, 16'h5A5A); exp_stop();
    pulse(2'b10, 0);
    tick(9);
    chk(glog_a.size() == 0 && req_cnt > 0, "R11 requests wait for grant", glog_a.size(), 0);
    gnt_en = 1'b1;
    drain(40, "R3 list B after strobe 1");
    if (glog_a.size() > 1)
      chk(glog_a[0] == 18'h20 && glog_a[1] == 18'h22, "R11 no word lost after retry", glog_a[1], 18'h22);

    // R7: hold with equality and greater-than boundaries
    beam_v = 8'h10; beam_h = 9'h000;
    set_loc(1, 18'h00040);
    exp_fetch(mem[32]); exp_fetch(mem[33]);
    pulse(2'b10, 0);
    drain(20, "R7 hold fetched");
    rc = req_cnt;
    beam_v = 8'h2F;
    tick(20);
    chk(req_cnt == rc, "R7 no request below vertical target", req_cnt, rc);
    exp_move(9'h050, 16'h1111); exp_fetch(mem[36]); exp_fetch(mem[37]);
    beam_v = 8'h30;
    drain(30, "R7 release at equal vertical");
    rc = req_cnt;
    beam_h = 9'h0FC;
    tick(20);
    chk(req_cnt == rc, "R7 no request below horizontal target", req_cnt, rc);
    exp_move(9'h052, 16'h1112); exp_stop();
    beam_h = 9'h104;
    drain(30, "R7 release above horizontal target");

    // R8: masks
    beam_v = 8'h05; beam_h = 9'h000;
    set_loc(1, 18'h00060);
    exp_fetch(mem[48]); exp_fetch(mem[49]); exp_move(9'h060, 16'h2222);
    exp_fetch(mem[52]); exp_fetch(mem[53]);
    pulse(2'b10, 0);
    drain(30, "R8 fully masked target passes");
    rc = req_cnt;
    tick(20);
    chk(req_cnt == rc, "R8 vertical bit 7 still compared", req_cnt, rc);
    exp_move(9'h062, 16'h3333); exp_stop();
    beam_v = 8'h80;
    drain(30, "R8 release when bit 7 reached");

    // R9: blitter gate (ignored case covered above with blit_done=0)
    beam_v = 8'h05; blit_done = 1'b0;
    set_loc(1, 18'h00080);
    exp_fetch(mem[64]); exp_fetch(mem[65]);
    pulse(2'b10, 0);
    drain(20, "R9 hold fetched");
    rc = req_cnt;
    tick(20);
    chk(req_cnt == rc, "R9 blocked until blitter finished", req_cnt, rc);
    exp_move(9'h070, 16'h4444); exp_stop();
    blit_done = 1'b1;
    drain(30, "R9 release on blitter finished");
    blit_done = 1'b0;

    // R10: bypass taken and not taken
    set_loc(1, 18'h000A0);
    clear_log();
    exp_fetch(mem[80]); exp_fetch(mem[81]); exp_move(9'h082, 16'hBBBB);
    exp_fetch(mem[86]); exp_fetch(mem[87]); exp_move(9'h084, 16'hCCCC); exp_stop();
    pulse(2'b10, 0);
    drain(60, "R10 bypass sequence");
    if (glog_a.size() > 2)
      chk(glog_a[2] == 18'hA8, "R10 bypass jumps over one pair", glog_a[2], 18'hA8);

    // R4: blanking restarts location 0
    exp_move(9'h040, 16'h1234); exp_move(9'h1FE, 16'hBEEF); exp_stop();
    pulse(2'b00, 1);
    drain(40, "R4 vblank reload");

    // R3: strobe priority
    set_loc(1, 18'h00020);
    exp_move(9'h040, 16'h1234); exp_move(9'h1FE, 16'hBEEF); exp_stop();
    pulse(2'b11, 0);
    drain(40, "R3 strobe 0 beats strobe 1");
    exp_move(9'h0AA, 16'h5A5A); exp_stop();
    pulse(2'b10, 1);
    drain(40, "R3 strobe beats vblank");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule